// File: doc/BRIEF.md
# Tiled Image Address Generator

This block turns element coordinates into byte addresses for an image kept in a tiled, bit-interleaved memory layout. The image is cut into square tiles that follow one another in row-major order. Inside a tile, elements are reordered by interleaving the low coordinate bits, where each x bit is XORed with its partner y bit. In the uncompressed mode a tile covers 16x16 pixels. In the block-compressed mode a tile covers 4x4 compressed blocks, and each block is moved as a single unit. The layout never alters element contents, so any element size in bytes can be used.

A host pulses `start_i` together with the image and rectangle settings. The block then walks the inclusive rectangle in raster order and offers one address per cycle on a valid/ready handshake. A one-cycle done pulse marks the end of the walk. Moving pixel data, compressing it and caching it are left to other blocks.

Top module: `tile_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `addr_valid_o` and `done_o` are low.
- R2: Uncompressed mode: the 8-bit in-tile index is built from the low four bits of x and y. Bit 0 is x0^y0, bit 1 is y0, bit 2 is x1^y1, bit 3 is y1, and so on up to bit 7, which is y3. For example, (1,0) gives 1, (0,1) gives 3, (1,1) gives 2 and (15,15) gives 170.
- R3: Tiles follow row-major order. The tile number is (y>>S)*tiles_per_row + (x>>S), where S is 4 in uncompressed mode. The element number is tile number * 256 + in-tile index.
- R4: Compressed mode (`cfg_blk_mode_i`=1): coordinates count blocks, S is 2, and the in-tile index is 4 bits wide (bit 0 x0^y0, bit 1 y0, bit 2 x1^y1, bit 3 y1). The element number is tile number * 16 + index.
- R5: Byte address = `cfg_base_i` + element number * `cfg_bpe_i`, taken modulo 2^ADDR_W.
- R6: The walk covers x0..x1 and y0..y1, both inclusive. It steps x first, then y, and issues each address exactly once.
- R7: While `addr_valid_o` is high and `addr_ready_i` is low, the next cycle keeps `addr_valid_o` high and `addr_o` unchanged.
- R8: `done_o` goes high for exactly one cycle, in the cycle after the final address is accepted. `addr_valid_o` is low in that cycle.
- R9: All settings are captured when a walk is launched. Changes to the settings during a walk, and `start_i` pulses during a walk, have no effect on the addresses produced.
- R10: A one-element rectangle (x0=x1, y0=y1) produces exactly one address and then done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches a walk when the block is idle |
| cfg_tiles_per_row_i | input | TPR_W | Image width counted in tiles |
| cfg_base_i | input | ADDR_W | Byte address of tile 0 |
| cfg_bpe_i | input | BPE_W | Bytes per element |
| cfg_blk_mode_i | input | 1 | 1 selects 4x4-block tiles for compressed formats |
| rect_x0_i | input | COORD_W | First column |
| rect_y0_i | input | COORD_W | First row |
| rect_x1_i | input | COORD_W | Last column, inclusive |
| rect_y1_i | input | COORD_W | Last row, inclusive |
| addr_o | output | ADDR_W | Byte address of the current element |
| addr_valid_o | output | 1 | `addr_o` holds a valid address |
| addr_ready_i | input | 1 | The consumer accepts `addr_o` |
| done_o | output | 1 | One-cycle pulse after the final accept |

## Verification
The first address becomes valid in the cycle after the clock edge that samples `start_i`. Each later address appears in the cycle after the edge that accepted the one before it, because the coordinate-to-address core is purely combinational on registered coordinates. `done_o` is due one cycle after the final accept. The bench drives ready and samples on the falling edge. At that edge it compares `addr_o` against the head of the expected queue whenever it is about to raise ready while valid is high, and it checks the done pulse at the very next falling edge after the final pop. When ready is withheld, the bench checks at the following falling edge that both the held address and valid are unchanged.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

  localparam int UNC_SIDE_LOG2 = 4;  // 16x16 elements per tile
  localparam int BLK_SIDE_LOG2 = 2;  // 4x4 blocks per tile
  localparam int UNC_IDX_W     = 2 * UNC_SIDE_LOG2;
  localparam int BLK_IDX_W     = 2 * BLK_SIDE_LOG2;
endpackage

// File: rtl/tile_swizzle.sv
module tile_swizzle #(
  parameter int PAIRS = 4
) (
  input  logic [PAIRS-1:0]   x_lo_i,
  input  logic [PAIRS-1:0]   y_lo_i,
  output logic [2*PAIRS-1:0] idx_o
);
  // each coordinate bit position yields a pair: low = x^y, high = y
  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    assign idx_o[2*g]   = x_lo_i[g] ^ y_lo_i[g];
    assign idx_o[2*g+1] = y_lo_i[g];
  end
endmodule

// File: rtl/tile_offset_calc.sv
module tile_offset_calc
  import tile_addr_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int TPR_W   = 8,
  parameter int BPE_W   = 5,
  parameter int ADDR_W  = 32
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [TPR_W-1:0]   tpr_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [BPE_W-1:0]   bpe_i,
  input  logic               blk_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [UNC_IDX_W-1:0] idx_unc;
  logic [BLK_IDX_W-1:0] idx_blk;
  logic [COORD_W-1:0]   tile_col;
  logic [COORD_W-1:0]   tile_row;
  logic [ADDR_W-1:0]    tile_lin;
  logic [ADDR_W-1:0]    elem_num;
  logic [ADDR_W-1:0]    byte_off;

  tile_swizzle #(.PAIRS(UNC_SIDE_LOG2)) swz_unc_i (
    .x_lo_i(x_i[UNC_SIDE_LOG2-1:0]),
    .y_lo_i(y_i[UNC_SIDE_LOG2-1:0]),
    .idx_o (idx_unc)
  );

  tile_swizzle #(.PAIRS(BLK_SIDE_LOG2)) swz_blk_i (
    .x_lo_i(x_i[BLK_SIDE_LOG2-1:0]),
    .y_lo_i(y_i[BLK_SIDE_LOG2-1:0]),
    .idx_o (idx_blk)
  );

  always_comb begin
    if (blk_i) begin
      tile_col = x_i >> BLK_SIDE_LOG2;
      tile_row = y_i >> BLK_SIDE_LOG2;
    end else begin
      tile_col = x_i >> UNC_SIDE_LOG2;
      tile_row = y_i >> UNC_SIDE_LOG2;
    end
    tile_lin = ADDR_W'(tile_row) * ADDR_W'(tpr_i) + ADDR_W'(tile_col);
    if (blk_i) elem_num = (tile_lin << BLK_IDX_W) | ADDR_W'(idx_blk);
    else       elem_num = (tile_lin << UNC_IDX_W) | ADDR_W'(idx_unc);
    byte_off = elem_num * ADDR_W'(bpe_i);
    addr_o   = base_i + byte_off;
  end
endmodule

// File: rtl/rect_walker.sv
module rect_walker
  import tile_addr_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [COORD_W-1:0] x0_i,
  input  logic [COORD_W-1:0] y0_i,
  input  logic [COORD_W-1:0] x1_i,
  input  logic [COORD_W-1:0] y1_i,
  input  logic               ready_i,
  output logic               launch_o,
  output logic               valid_o,
  output logic               done_o,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o
);
  walk_state_e        state_q, state_d;
  logic [COORD_W-1:0] x_q, x_d, y_q, y_d;
  logic [COORD_W-1:0] xs_q, xe_q, ye_q;
  logic               done_q, done_d;
  logic               accept, last_x, last_y, step_en;

  assign valid_o  = (state_q == WALK_RUN);
  assign launch_o = (state_q == WALK_IDLE) && start_i;
  assign accept   = valid_o && ready_i;
  assign last_x   = (x_q == xe_q);
  assign last_y   = (y_q == ye_q);
  assign step_en  = launch_o || accept;

  always_comb begin
    state_d = state_q;
    x_d     = x_q;
    y_d     = y_q;
    done_d  = 1'b0;
    if (launch_o) begin
      state_d = WALK_RUN;
      x_d     = x0_i;
      y_d     = y0_i;
    end else if (accept) begin
      if (!last_x) begin
        x_d = x_q + 1'b1;
      end else if (!last_y) begin
        x_d = xs_q;
        y_d = y_q + 1'b1;
      end else begin
        state_d = WALK_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step_en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs_q <= '0;
      xe_q <= '0;
      ye_q <= '0;
    end else if (launch_o) begin
      xs_q <= x0_i;
      xe_q <= x1_i;
      ye_q <= y1_i;
    end
  end

  assign done_o = done_q;
  assign x_o    = x_q;
  assign y_o    = y_q;
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_addr_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int TPR_W   = 8,
  parameter int BPE_W   = 5,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [TPR_W-1:0]   cfg_tiles_per_row_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic [BPE_W-1:0]   cfg_bpe_i,
  input  logic               cfg_blk_mode_i,
  input  logic [COORD_W-1:0] rect_x0_i,
  input  logic [COORD_W-1:0] rect_y0_i,
  input  logic [COORD_W-1:0] rect_x1_i,
  input  logic [COORD_W-1:0] rect_y1_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               addr_valid_o,
  input  logic               addr_ready_i,
  output logic               done_o
);
  logic               launch;
  logic [COORD_W-1:0] cur_x, cur_y;
  logic [TPR_W-1:0]   tpr_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BPE_W-1:0]   bpe_q;
  logic               blk_q;

  rect_walker #(.COORD_W(COORD_W)) walker_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .x0_i    (rect_x0_i),
    .y0_i    (rect_y0_i),
    .x1_i    (rect_x1_i),
    .y1_i    (rect_y1_i),
    .ready_i (addr_ready_i),
    .launch_o(launch),
    .valid_o (addr_valid_o),
    .done_o  (done_o),
    .x_o     (cur_x),
    .y_o     (cur_y)
  );

  // settings captured once per walk (clock enable = launch)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q  <= '0;
      base_q <= '0;
      bpe_q  <= '0;
      blk_q  <= 1'b0;
    end else if (launch) begin
      tpr_q  <= cfg_tiles_per_row_i;
      base_q <= cfg_base_i;
      bpe_q  <= cfg_bpe_i;
      blk_q  <= cfg_blk_mode_i;
    end
  end

  tile_offset_calc #(
    .COORD_W(COORD_W), .TPR_W(TPR_W), .BPE_W(BPE_W), .ADDR_W(ADDR_W)
  ) calc_i (
    .x_i   (cur_x),
    .y_i   (cur_y),
    .tpr_i (tpr_q),
    .base_i(base_q),
    .bpe_i (bpe_q),
    .blk_i (blk_q),
    .addr_o(addr_o)
  );
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_valid_o,
  input logic              addr_ready_i,
  input logic              done_o
);
  // R1: nothing offered while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!addr_valid_o && !done_o));

  // R7: stalled offer stays valid and unchanged
  a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i) |=> addr_valid_o);

  a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i) |=> $stable(addr_o));

  // R8: done is a single-cycle pulse that follows an accept
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(addr_valid_o && addr_ready_i));

  a_r8_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !addr_valid_o);
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_o      (addr_o),
  .addr_valid_o(addr_valid_o),
  .addr_ready_i(addr_ready_i),
  .done_o      (done_o)
);

// File: tb/tile_addr_gen_tb_top.sv
`timescale 1ns/1ps
module tile_addr_gen_tb_top;
  localparam int COORD_W = 12;
  localparam int TPR_W   = 8;
  localparam int BPE_W   = 5;
  localparam int ADDR_W  = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [TPR_W-1:0]   cfg_tiles_per_row_i = '0;
  logic [ADDR_W-1:0]  cfg_base_i = '0;
  logic [BPE_W-1:0]   cfg_bpe_i = '0;
  logic               cfg_blk_mode_i = 1'b0;
  logic [COORD_W-1:0] rect_x0_i = '0, rect_y0_i = '0, rect_x1_i = '0, rect_y1_i = '0;
  logic [ADDR_W-1:0]  addr_o;
  logic               addr_valid_o;
  logic               addr_ready_i = 1'b0;
  logic               done_o;

  int checks = 0;
  int errors = 0;

  logic [ADDR_W-1:0] exp_q[$];
  string             tag_q[$];

  logic        rdy_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_hold = 1'b0;
  logic [ADDR_W-1:0] held_addr = '0;
  logic        final_pending = 1'b0;
  logic        job_done = 1'b0;

  always #5 clk = ~clk;

  tile_addr_gen #(
    .COORD_W(COORD_W), .TPR_W(TPR_W), .BPE_W(BPE_W), .ADDR_W(ADDR_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cfg_tiles_per_row_i(cfg_tiles_per_row_i), .cfg_base_i(cfg_base_i),
    .cfg_bpe_i(cfg_bpe_i), .cfg_blk_mode_i(cfg_blk_mode_i),
    .rect_x0_i(rect_x0_i), .rect_y0_i(rect_y0_i),
    .rect_x1_i(rect_x1_i), .rect_y1_i(rect_y1_i),
    .addr_o(addr_o), .addr_valid_o(addr_valid_o),
    .addr_ready_i(addr_ready_i), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // independent address model built from R2..R5
  function automatic logic [ADDR_W-1:0] model_addr(int tpr, longint base, int bpe,
                                                   bit blk, int x, int y);
    int side = blk ? 2 : 4;
    longint idx = 0;
    longint tile;
    longint elem;
    for (int i = 0; i < side; i++) begin
      idx += longint'(((x >> i) ^ (y >> i)) & 1) << (2 * i);
      idx += longint'((y >> i) & 1) << (2 * i + 1);
    end
    tile = longint'(y >> side) * tpr + longint'(x >> side);
    elem = tile * (blk ? 16 : 256) + idx;
    return ADDR_W'(base + elem * bpe);
  endfunction

  task automatic push_exp(input logic [ADDR_W-1:0] a, input string req);
    exp_q.push_back(a);
    tag_q.push_back(req);
  endtask

  task automatic launch(input int tpr, input longint base, input int bpe, input bit blk,
                        input int x0, input int y0, input int x1, input int y1,
                        input bit disturb);
    @(negedge clk);
    cfg_tiles_per_row_i = TPR_W'(tpr);
    cfg_base_i          = ADDR_W'(base);
    cfg_bpe_i           = BPE_W'(bpe);
    cfg_blk_mode_i      = blk;
    rect_x0_i = COORD_W'(x0); rect_y0_i = COORD_W'(y0);
    rect_x1_i = COORD_W'(x1); rect_y1_i = COORD_W'(y1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      // R9: new settings and a start pulse mid-walk must be ignored
      repeat (3) @(negedge clk);
      cfg_tiles_per_row_i = 8'd9;
      cfg_base_i          = 32'h0BAD_0000;
      cfg_bpe_i           = 5'd3;
      cfg_blk_mode_i      = ~blk;
      rect_x0_i = 12'd100; rect_y0_i = 12'd100;
      rect_x1_i = 12'd101; rect_y1_i = 12'd101;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!job_done) @(negedge clk);
    job_done = 1'b0;
  endtask

  task automatic model_job(input int tpr, input longint base, input int bpe, input bit blk,
                           input int x0, input int y0, input int x1, input int y1,
                           input bit disturb, input string req);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        push_exp(model_addr(tpr, base, bpe, blk, x, y), req);
    launch(tpr, base, bpe, blk, x0, y0, x1, y1, disturb);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      logic rdy;
      if (final_pending) begin
        check(done_o === 1'b1 && addr_valid_o === 1'b0, "R8 done", {done_o, addr_valid_o}, 2'b10);
        final_pending = 1'b0;
        job_done = 1'b1;
      end else if (done_o !== 1'b0) begin
        check(1'b0, "R8 stray done", done_o, 0);
      end
      if (prev_hold)
        check(addr_valid_o === 1'b1 && addr_o === held_addr, "R7 hold", addr_o, held_addr);
      rdy  = rdy_mode ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      addr_ready_i = rdy;
      if (addr_valid_o === 1'b1) begin
        if (rdy) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 extra address", addr_o, 0);
          end else begin
            logic [ADDR_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(addr_o === e, t, addr_o, e);
            if (exp_q.size() == 0) final_pending = 1'b1;
          end
        end
        prev_hold = !rdy;
        held_addr = addr_o;
      end else begin
        prev_hold = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(addr_valid_o === 1'b0 && done_o === 1'b0, "R1 in reset", {addr_valid_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(addr_valid_o === 1'b0 && done_o === 1'b0, "R1 after release", {addr_valid_o, done_o}, 0);

    // R2 / R6: 2x2 corner of tile 0, literal indices, raster order
    push_exp(32'd0, "R2 (0,0)");
    push_exp(32'd1, "R2 (1,0)");
    push_exp(32'd3, "R2 (0,1)");
    push_exp(32'd2, "R2 (1,1)");
    launch(1, 0, 1, 1'b0, 0, 0, 1, 1, 1'b0);

    // R2 / R10: single element at (15,15)
    push_exp(32'd170, "R2 R10 (15,15)");
    launch(1, 0, 1, 1'b0, 15, 15, 15, 15, 1'b0);

    // R3: second tile in a row, first tile of second row
    push_exp(32'd256, "R3 tile col 1");
    launch(2, 0, 1, 1'b0, 16, 0, 16, 0, 1'b0);
    push_exp(32'd768, "R3 tile row 1");
    launch(3, 0, 1, 1'b0, 0, 16, 0, 16, 1'b0);

    // R5: base plus scaled offset
    push_exp(32'h0000_1004, "R5 bpe 4");
    launch(1, 32'h1000, 4, 1'b0, 1, 0, 1, 0, 1'b0);

    // R4: compressed blocks, 8 bytes per block
    push_exp(32'd16,  "R4 (1,1)");
    launch(1, 0, 8, 1'b1, 1, 1, 1, 1, 1'b0);
    push_exp(32'd128, "R4 (4,0) tile 1");
    launch(2, 0, 8, 1'b1, 4, 0, 4, 0, 1'b0);
    push_exp(32'd80,  "R4 (3,3)");
    launch(1, 0, 8, 1'b1, 3, 3, 3, 3, 1'b0);

    // R6 / R7: larger rectangle across tile edges, irregular ready
    rdy_mode = 1'b1;
    model_job(4, 32'h4000_0000, 4, 1'b0, 13, 14, 20, 18, 1'b0, "R6 R7 raster");
    model_job(3, 32'h0000_2000, 16, 1'b1, 2, 1, 6, 5, 1'b0, "R4 R7 blk rect");

    // R9: disturbance during a walk
    model_job(2, 32'h0001_0000, 2, 1'b0, 5, 2, 9, 4, 1'b1, "R9 ignore");

    // R5: address wraps modulo 2^ADDR_W
    rdy_mode = 1'b0;
    model_job(1, 32'hFFFF_FFF0, 8, 1'b0, 2, 0, 3, 0, 1'b0, "R5 wrap");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule